// File: doc/BRIEF.md
# Microcoded Accumulator Control Sequencer

This block is the control unit of a small accumulator machine, built around a stored table of control words instead of per-signal gate equations. Each word holds one bit for every datapath strobe, a flag that starts opcode dispatch, a flag that lets the accumulator-zero condition steer the next step, and a 5-bit next-address field. A 5-bit microaddress register picks the active word on every clock. Address formation never adds: the next address is either copied from the word, copied from the word with the condition bit or'ed into its lowest bit, or built from the opcode padded with zero bits.

The datapath beside it has a program counter, a memory address register, a memory data register, an instruction register, an accumulator and an adder result register, all joined by one internal bus. Memory is outside the block. It is reached through an address port, read and write strobes, write data, and read data that must follow the address within the same cycle. The block runs four instructions: load, add, store, and branch-if-accumulator-zero. The current microaddress and the control strobes are brought out so that the step-by-step sequencing can be observed.

Top module: `ucode_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `uAddr` is 0 and `ctlBits` shows only the fetch strobes pcOut and marIn. The program counter and the accumulator start at 0.
- R2: Fetch runs through microaddresses 0, 1, 2 and 3 in order. Address 0 drives pcOut and marIn. Address 1 drives memRd and pcIncr. Address 2 drives mdrOut and irIn. Address 3 drives no strobe.
- R3: The word at address 3 dispatches. The next microaddress is {1'b1, opcode, 2'b00}, which gives 16 for load, 20 for add, 24 for store and 28 for branch.
- R4: Inside a routine, the next address is taken from the word's next-address field. Every routine hands back to address 0. A whole instruction takes 7 cycles for load, 8 for add, 7 for store and 6 for branch.
- R5: The branch word at 28 has the condition flag set and a next-address field of 30. The accumulator-zero condition is or'ed into bit 0 of that field. Address 31 (taken) drives irOutAddr and pcIn, which loads the PC with the instruction's address field. Address 30 (not taken) drives nothing.
- R6: `ctlBits` bit order, MSB to LSB: accIn, accOut, aluAdd, irIn, irOutAddr, marIn, mdrIn, mdrOut, pcIn, pcOut, pcIncr, memRd, tempOut, memWr (bit 13 down to bit 0). After dispatch, each step's strobes are as follows. Load: {irOutAddr, marIn}, {memRd}, {mdrOut, accIn}. Add: {irOutAddr, marIn}, {memRd}, {accOut, aluAdd}, {tempOut, accIn}. Store: {irOutAddr, marIn}, {accOut, mdrIn}, {memWr}.
- R7: The instruction word is opcode in bits [7:6] (load=0, add=1, store=2, branch=3) and address in bits [5:0]. Load sets ACC to mem[a]. Add sets ACC to ACC+mem[a] modulo 256. Store writes ACC to mem[a]. The final memory contents match an instruction-level model.
- R8: `memAddr` is the address register. When `memRead` is high, `memAddr` is the PC during fetch and the operand address during execute. When `memWrite` is high, `memWdata` equals the accumulator. `memRead` and `memWrite` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memRdata | input | 8 | Memory read data, combinational from memAddr |
| memAddr | output | 6 | Memory address (address register) |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe, write happens at the clock edge |
| memWdata | output | 8 | Memory write data (data register) |
| uAddr | output | 5 | Current microaddress |
| ctlBits | output | 14 | Control strobes of the current word, order per R6 |

## Verification
The bench builds the block with an 8-bit data word, a 2-bit opcode and a 5-bit microaddress, which gives a 64-word memory and a 32-word control store. At that size, one short program drives every opcode, both branch outcomes and an add that wraps past 255. Sixteen runs with arithmetically varied data compare every cycle's strobes, microaddress and memory traffic against a step-level model, and then compare all 64 memory words.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W = 5;

  typedef struct packed {
    logic accIn;
    logic accOut;
    logic aluAdd;
    logic irIn;
    logic irOutAddr;
    logic marIn;
    logic mdrIn;
    logic mdrOut;
    logic pcIn;
    logic pcOut;
    logic pcIncr;
    logic memRd;
    logic tempOut;
    logic memWr;
  } ctlStrobes_t;

  localparam int CTL_W = $bits(ctlStrobes_t);

  typedef struct packed {
    ctlStrobes_t       ctl;
    logic              dispatch;
    logic              condSel;
    logic [UA_W-1:0]   nextAddr;
  } uWord_t;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uWord_t          word
);
  always_comb begin
    word = '0;
    case (int'(addr))
      // fetch
      0:  begin word.ctl.pcOut = 1'b1; word.ctl.marIn = 1'b1; word.nextAddr = 5'd1; end
      1:  begin word.ctl.memRd = 1'b1; word.ctl.pcIncr = 1'b1; word.nextAddr = 5'd2; end
      2:  begin word.ctl.mdrOut = 1'b1; word.ctl.irIn = 1'b1; word.nextAddr = 5'd3; end
      3:  word.dispatch = 1'b1;
      // load
      16: begin word.ctl.irOutAddr = 1'b1; word.ctl.marIn = 1'b1; word.nextAddr = 5'd17; end
      17: begin word.ctl.memRd = 1'b1; word.nextAddr = 5'd18; end
      18: begin word.ctl.mdrOut = 1'b1; word.ctl.accIn = 1'b1; end
      // add
      20: begin word.ctl.irOutAddr = 1'b1; word.ctl.marIn = 1'b1; word.nextAddr = 5'd21; end
      21: begin word.ctl.memRd = 1'b1; word.nextAddr = 5'd22; end
      22: begin word.ctl.accOut = 1'b1; word.ctl.aluAdd = 1'b1; word.nextAddr = 5'd23; end
      23: begin word.ctl.tempOut = 1'b1; word.ctl.accIn = 1'b1; end
      // store
      24: begin word.ctl.irOutAddr = 1'b1; word.ctl.marIn = 1'b1; word.nextAddr = 5'd25; end
      25: begin word.ctl.accOut = 1'b1; word.ctl.mdrIn = 1'b1; word.nextAddr = 5'd26; end
      26: word.ctl.memWr = 1'b1;
      // branch on zero
      28: begin word.condSel = 1'b1; word.nextAddr = 5'd30; end
      31: begin word.ctl.irOutAddr = 1'b1; word.ctl.pcIn = 1'b1; end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPC_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  input  logic             accZero,
  output ctlStrobes_t      ctl,
  output logic [UA_W-1:0]  uAddr
);
  localparam int SLOT_W = UA_W - 1 - OPC_W;

  uWord_t          word;
  logic [UA_W-1:0] dispatchAddr;
  logic [UA_W-1:0] nextUAddr;

  useq_rom romI (.addr(uAddr), .word(word));

  assign dispatchAddr = {1'b1, opcode, {SLOT_W{1'b0}}};

  always_comb begin
    if (word.dispatch) nextUAddr = dispatchAddr;
    else nextUAddr = word.nextAddr | {{(UA_W-1){1'b0}}, word.condSel & accZero};
  end

  always_ff @(posedge clk) begin
    if (!rstN) uAddr <= '0;
    else uAddr <= nextUAddr;
  end

  assign ctl = word.ctl;
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import useq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPC_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                ctl,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [DATA_W-OPC_W-1:0]    memAddr,
  output logic [DATA_W-1:0]          memWdata,
  output logic [OPC_W-1:0]           opcode,
  output logic                       accZero
);
  localparam int ADDR_W = DATA_W - OPC_W;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, ir, acc, temp, bus;

  always_comb begin
    bus = '0;
    if (ctl.pcOut)     bus = {{OPC_W{1'b0}}, pc};
    if (ctl.irOutAddr) bus = {{OPC_W{1'b0}}, ir[ADDR_W-1:0]};
    if (ctl.mdrOut)    bus = mdr;
    if (ctl.accOut)    bus = acc;
    if (ctl.tempOut)   bus = temp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0; acc <= '0; temp <= '0;
    end else begin
      if (ctl.marIn) mar <= bus[ADDR_W-1:0];
      if (ctl.pcIn) pc <= bus[ADDR_W-1:0];
      else if (ctl.pcIncr) pc <= pc + 1'b1;
      if (ctl.memRd) mdr <= memRdata;
      else if (ctl.mdrIn) mdr <= bus;
      if (ctl.irIn) ir <= bus;
      if (ctl.accIn) acc <= bus;
      if (ctl.aluAdd) temp <= bus + mdr;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mdr;
  assign opcode   = ir[DATA_W-1:ADDR_W];
  assign accZero  = (acc == '0);
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import useq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPC_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [DATA_W-OPC_W-1:0]  memAddr,
  output logic                     memRead,
  output logic                     memWrite,
  output logic [DATA_W-1:0]        memWdata,
  output logic [UA_W-1:0]          uAddr,
  output logic [CTL_W-1:0]         ctlBits
);
  ctlStrobes_t      ctl;
  logic [OPC_W-1:0] opcode;
  logic             accZero;

  useq_ctrl #(.OPC_W(OPC_W)) ctrlI (
    .clk(clk), .rstN(rstN), .opcode(opcode), .accZero(accZero),
    .ctl(ctl), .uAddr(uAddr)
  );

  acc_datapath #(.DATA_W(DATA_W), .OPC_W(OPC_W)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .opcode(opcode), .accZero(accZero)
  );

  assign memRead  = ctl.memRd;
  assign memWrite = ctl.memWr;
  assign ctlBits  = ctl;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] uAddr,
  input logic       memRead,
  input logic       memWrite
);
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == 5'd0 || uAddr == 5'd1 || uAddr == 5'd2) |=> uAddr == $past(uAddr) + 5'd1);

  // R3
  dispatch_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == 5'd3) |=> (uAddr[4] && uAddr[1:0] == 2'b00));

  // R5
  cond_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == 5'd28) |=> (uAddr[4:1] == 4'b1111));

  // R4
  routine_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uAddr == 5'd18 || uAddr == 5'd23 || uAddr == 5'd26 || uAddr == 5'd30 || uAddr == 5'd31)
    |=> uAddr == 5'd0);

  // R8
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));
endmodule

bind ucode_seq ucode_seq_chk chkI (
  .clk(clk), .rstN(rstN), .uAddr(uAddr), .memRead(memRead), .memWrite(memWrite)
);

// File: tb/ucode_seq_test.sv
module ucode_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] memRdata;
  logic [5:0] memAddr;
  logic       memRead, memWrite;
  logic [7:0] memWdata;
  logic [4:0] uAddr;
  logic [13:0] ctlBits;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] mem [64];
  logic [7:0] refMem [64];
  int pcR, accR, stepR, opR, aR;

  always #5 clk = ~clk;

  ucode_seq uut (
    .clk(clk), .rstN(rstN), .memRdata(memRdata), .memAddr(memAddr),
    .memRead(memRead), .memWrite(memWrite), .memWdata(memWdata),
    .uAddr(uAddr), .ctlBits(ctlBits)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWrite) mem[memAddr] <= memWdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // strobe positions per R6
  function automatic logic [13:0] bitsOf(input int a, input int b);
    logic [13:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    return v;
  endfunction

  function automatic logic [13:0] expCtl(input int s, input int op, input bit z);
    case (s)
      0: return bitsOf(4, 8);
      1: return bitsOf(2, 3);
      2: return bitsOf(6, 10);
      3: return '0;
      default: ;
    endcase
    case (op)
      0: return s == 4 ? bitsOf(9, 8) : s == 5 ? bitsOf(2, -1) : bitsOf(6, 13);
      1: return s == 4 ? bitsOf(9, 8) : s == 5 ? bitsOf(2, -1) : s == 6 ? bitsOf(12, 11) : bitsOf(1, 13);
      2: return s == 4 ? bitsOf(9, 8) : s == 5 ? bitsOf(12, 7) : bitsOf(0, -1);
      default: return (s == 5 && z) ? bitsOf(9, 5) : '0;
    endcase
  endfunction

  function automatic int expUAddr(input int s, input int op, input bit z);
    if (s < 4) return s;
    if (op == 3 && s == 5) return z ? 31 : 30;
    return 16 + op * 4 + (s - 4);
  endfunction

  function automatic int lastStep(input int op);
    return op == 1 ? 7 : op == 3 ? 5 : 6;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic stepCheck();
    bit z = (accR == 0);
    if (stepR == 0) begin
      opR = int'(refMem[pcR][7:6]);
      aR  = int'(refMem[pcR][5:0]);
    end
    // R2 R3 R4 R5 R6: strobes and microaddress per step
    check(ctlBits == expCtl(stepR, opR, z), "R6 ctlBits", int'(ctlBits), int'(expCtl(stepR, opR, z)));
    check(int'(uAddr) == expUAddr(stepR, opR, z), "R4 uAddr", int'(uAddr), expUAddr(stepR, opR, z));
    // R8: memory traffic
    check(!(memRead && memWrite), "R8 excl", int'({memRead, memWrite}), 0);
    if (memRead) check(int'(memAddr) == (stepR == 1 ? pcR : aR), "R8 rdAddr", int'(memAddr), stepR == 1 ? pcR : aR);
    if (memWrite) begin
      check(int'(memAddr) == aR, "R8 wrAddr", int'(memAddr), aR);
      check(int'(memWdata) == accR, "R8 wrData", int'(memWdata), accR);
    end
    if (stepR == 1) pcR = (pcR + 1) % 64;
    if (stepR == lastStep(opR)) begin
      case (opR)
        0: accR = int'(refMem[aR]);
        1: accR = (accR + int'(refMem[aR])) % 256;
        2: refMem[aR] = 8'(accR);
        default: if (accR == 0) pcR = aR;
      endcase
      stepR = 0;
    end else stepR++;
  endtask

  initial begin
    for (int run = 0; run < 16; run++) begin
      rstN = 1'b0;
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      mem[0] = {2'd0, 6'd48}; mem[1] = {2'd3, 6'd4};  mem[2] = {2'd2, 6'd60};
      mem[3] = {2'd2, 6'd61}; mem[4] = {2'd0, 6'd49}; mem[5] = {2'd1, 6'd50};
      mem[6] = {2'd1, 6'd51}; mem[7] = {2'd2, 6'd52}; mem[8] = {2'd3, 6'd10};
      mem[9] = {2'd1, 6'd53}; mem[10] = {2'd2, 6'd54}; mem[11] = {2'd3, 6'd11};
      mem[12] = {2'd1, 6'd49}; mem[13] = {2'd2, 6'd55}; mem[14] = {2'd3, 6'd11};
      mem[48] = (run % 2) ? 8'(run) : 8'd0;
      mem[49] = 8'(run * 17);
      mem[50] = 8'(255 - run * 3);
      mem[51] = 8'(run);
      mem[53] = 8'(run * 7 + 1);
      for (int i = 0; i < 64; i++) refMem[i] = mem[i];
      pcR = 0; accR = 0; stepR = 0; opR = 0; aR = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(uAddr == 5'd0, "R1 uAddr", int'(uAddr), 0);
      check(ctlBits == bitsOf(4, 8), "R1 ctlBits", int'(ctlBits), int'(bitsOf(4, 8)));
      rstN = 1'b1;
      for (int c = 0; c < 280; c++) begin
        stepCheck();
        @(negedge clk);
      end
      // R7: final memory image
      for (int i = 0; i < 64; i++)
        check(mem[i] == refMem[i], "R7 mem", int'(mem[i]), int'(refMem[i]));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule